// File: doc/BRIEF.md
# Prescaled Clock Divider with Pulse-Safe Output Gate

This block turns an already selected master clock into the main output clock. The master clock passes through an optional fixed prescaler of 2 or 4 and then through an integer divider. The divider takes its ratio from a 9-bit code. A full-bypass setting sends the master clock itself to the output. Configuration is static while the block runs and changes only while the output is disabled.

The output-enable input is active high and first passes through a synchronizer. Dropping it never shortens a high pulse. While the output is disabled, the prescaler and the divider stay cleared. When the enable returns, the output therefore starts with a fixed phase relative to the enable edge.

Top module: `prescale_div_gate`

## Requirements
- R1: The divider ratio D equals `div_code` + 2. With prescale factor P, the period of `clk_out` is P*D master cycles. Code 0 gives D = 2 and code 511 gives D = 513.
- R2: With the internal reference (`ext_ref` = 0), `pre_skip` = 0 and `full_skip` = 0, P is 4 when `pre_half` = 0 and 2 when `pre_half` = 1.
- R3: With `pre_skip` = 1, P = 1 and `pre_half` has no effect on the period.
- R4: With `full_skip` = 1, `clk_out` follows the master clock while enabled, whatever `div_code`, `pre_half` and `pre_skip` hold. Once the synchronized enable is low, `clk_out` stays low without cutting a high phase.
- R5: With `ext_ref` = 1, the prescaler is never applied (P = 1), even when `pre_skip` = 0.
- R6: Each high phase of `clk_out` lasts P*ceil(D/2) master cycles and each low phase lasts P*floor(D/2).
- R7: When the enable falls while `clk_out` is high, the current high phase runs to its full length and the output then stays low. When the enable falls while `clk_out` is low, no further high phase begins.
- R8: While disabled, the prescaler and divider are cleared. If `out_en` is first sampled high at rising edge k, `clk_out` is low after edges k and k+1, rises at edge k+2, and then runs the normal pattern of R6.
- R9: `clk_out` is low during reset and stays low after reset while `out_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Selected master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_code | input | 9 | Divider code; the ratio is code + 2 |
| pre_half | input | 1 | Prescaler ratio: 0 gives /4, 1 gives /2 |
| pre_skip | input | 1 | 1 skips the prescaler |
| full_skip | input | 1 | 1 routes the gated master clock to the output |
| ext_ref | input | 1 | 1 means the external reference is in use; disables the prescaler |
| out_en | input | 1 | Asynchronous active-high output enable |
| clk_out | output | 1 | Divided and gated output clock |

## Verification
The bench sweeps every code from 0 to 31 under prescale factors 1, 2 and 4, and adds codes 255 and 511. For each case it measures the start latency, the high time, the low time and a second high time. Odd and even codes tell the ceil and floor split apart. The three prescale factors show that `pre_half`, `pre_skip` and `ext_ref` select the factor correctly. Separate runs drop the enable in the middle of a high phase and during a low phase, to tell a clipped pulse from a held output. The full-bypass runs sample both clock phases, with the enable on and with it off.

// File: rtl/pdg_pkg.sv
package pdg_pkg;

  localparam int RATIO_W = 3;

  // Effective prescale factor: external reference or explicit skip gives 1.
  function automatic logic [RATIO_W-1:0] prescale_factor(
    input logic half,
    input logic skip,
    input logic ext
  );
    logic [RATIO_W-1:0] f;
    if (ext || skip) begin
      f = 3'd1;
    end else if (half) begin
      f = 3'd2;
    end else begin
      f = 3'd4;
    end
    return f;
  endfunction

endpackage

// File: rtl/pdg_sync.sv
module pdg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_comb chain_d[i] = d;
      end else begin : g_next
        always_comb chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/pdg_prescale.sv
module pdg_prescale
  import pdg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);

  localparam int CW = RATIO_W - 1;

  logic [CW-1:0] pre_q;
  logic [CW-1:0] pre_d;
  logic          at_end;

  // Tick on count zero so the first active cycle after a clear already ticks.
  always_comb begin
    tick   = (pre_q == '0);
    at_end = ({1'b0, pre_q} == (ratio - 3'd1));
    if (clr || at_end) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, pre_q} < ratio)); // R2

  AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> tick); // R8

endmodule

// File: rtl/pdg_divider.sv
module pdg_divider #(
  parameter int CODE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              en_s,
  input  logic              freeze,
  input  logic [CODE_W-1:0] code,
  output logic              out_q,
  output logic              hold
);

  localparam int CNT_W = CODE_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             out_d;
  logic [CNT_W-1:0] hi_m1;
  logic [CNT_W-1:0] lo_m1;

  // High phase spans ceil(D/2) ticks, low phase floor(D/2), with D = code + 2.
  always_comb begin
    hi_m1 = ({1'b0, code} + 1'b1) >> 1;
    lo_m1 = {1'b0, code} >> 1;
  end

  // Disabled and low (or in full bypass): hold everything cleared.
  always_comb begin
    hold  = freeze || (!en_s && !out_q);
    cnt_d = cnt_q;
    out_d = out_q;
    if (hold) begin
      cnt_d = '0;
      out_d = 1'b0;
    end else if (tick) begin
      if (cnt_q == '0) begin
        out_d = !out_q;
        cnt_d = out_q ? lo_m1 : hi_m1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      out_q <= out_d;
    end
  end

  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_s && !out_q) |=> !out_q); // R7

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_q |-> (cnt_q <= hi_m1)); // R6

endmodule

// File: rtl/pdg_bypass_gate.sv
module pdg_bypass_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  output logic gate
);

  logic gate_d;

  always_comb gate_d = en_s;

  // Updated while the clock is low, so an AND with the clock cannot glitch.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate <= 1'b0;
    end else begin
      gate <= gate_d;
    end
  end

endmodule

// File: rtl/prescale_div_gate.sv
module prescale_div_gate
  import pdg_pkg::*;
#(
  parameter int CODE_W      = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] div_code,
  input  logic              pre_half,
  input  logic              pre_skip,
  input  logic              full_skip,
  input  logic              ext_ref,
  input  logic              out_en,
  output logic              clk_out
);

  localparam int LEN_W = CODE_W + RATIO_W + 1;

  logic               rst_s_n;
  logic               en_s;
  logic [RATIO_W-1:0] ratio;
  logic               tick;
  logic               div_out;
  logic               div_hold;
  logic               gate;

  pdg_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_s_n)
  );

  pdg_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     (out_en),
    .q     (en_s)
  );

  always_comb ratio = prescale_factor(pre_half, pre_skip, ext_ref);

  pdg_prescale u_prescale (
    .clk   (clk),
    .rst_n (rst_s_n),
    .clr   (div_hold),
    .ratio (ratio),
    .tick  (tick)
  );

  pdg_divider #(.CODE_W(CODE_W)) u_divider (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .tick   (tick),
    .en_s   (en_s),
    .freeze (full_skip),
    .code   (div_code),
    .out_q  (div_out),
    .hold   (div_hold)
  );

  pdg_bypass_gate u_gate (
    .clk   (clk),
    .rst_n (rst_s_n),
    .en_s  (en_s),
    .gate  (gate)
  );

  assign clk_out = full_skip ? (clk & gate) : div_out;

  // Checker: length of the current high phase in master cycles.
  logic [LEN_W-1:0] hi_len;
  logic [LEN_W-1:0] exp_hi;

  always_comb exp_hi = LEN_W'((({1'b0, div_code} + 3) >> 1) * ratio);

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      hi_len <= '0;
    end else if (div_out) begin
      hi_len <= hi_len + 1'b1;
    end else begin
      hi_len <= '0;
    end
  end

  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(div_out) |-> ($past(hi_len) == exp_hi - 1'b1)); // R7

  AST_BYPASS_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    full_skip |=> !div_out); // R4

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_s_n |-> !div_out); // R9

endmodule

// File: tb/prescale_div_gate_tb.sv
module prescale_div_gate_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk;
  logic       rst_n;
  logic [8:0] div_code;
  logic       pre_half;
  logic       pre_skip;
  logic       full_skip;
  logic       ext_ref;
  logic       out_en;
  logic       clk_out;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  prescale_div_gate u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_code  (div_code),
    .pre_half  (pre_half),
    .pre_skip  (pre_skip),
    .full_skip (full_skip),
    .ext_ref   (ext_ref),
    .out_en    (out_en),
    .clk_out   (clk_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      n_chk  = n_chk + 1;
      n_fail = n_fail + 1;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic smp(output logic v);
    @(negedge clk);
    v = clk_out;
  endtask

  // Disable, wait until the output rests low, then apply a configuration.
  task automatic park(input int code, input logic h, input logic ps, input logic e);
    logic v;
    out_en = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5000; i++) begin
      smp(v);
      if (v == 1'b0) break;
    end
    repeat (2) @(negedge clk);
    div_code = 9'(code);
    pre_half = h;
    pre_skip = ps;
    ext_ref  = e;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_len(input logic lvl, output int n);
    logic v;
    n = 1;
    for (int i = 0; i < 5000; i++) begin
      smp(v);
      if (v !== lvl) break;
      n = n + 1;
    end
  endtask

  task automatic run_cfg(input int code, input logic h, input logic ps,
                         input logic e, input string tag);
    int p, d, hi, lo, hi2, st;
    logic s1, s2, s3;
    p = (e || ps) ? 1 : (h ? 2 : 4);
    d = code + 2;
    park(code, h, ps, e);
    out_en = 1'b1;
    smp(s1);
    smp(s2);
    smp(s3);
    st = {29'd0, s1, s2, s3};
    chk("R8 start latency", st, 1);
    run_len(1'b1, hi);
    run_len(1'b0, lo);
    run_len(1'b1, hi2);
    chk("R6 high time", hi, p * ((d + 1) / 2));
    chk("R6 low time", lo, p * (d / 2));
    chk(tag, hi + lo, p * d);
    chk("R8 repeat high", hi2, p * ((d + 1) / 2));
  endtask

  initial begin
    logic v;
    int   bad;
    int   cnt;
    rst_n     = 1'b0;
    div_code  = 9'd0;
    pre_half  = 1'b0;
    pre_skip  = 1'b1;
    full_skip = 1'b0;
    ext_ref   = 1'b0;
    out_en    = 1'b0;

    // R9: low in reset and afterwards while disabled
    repeat (3) @(negedge clk);
    chk("R9 in reset", int'(clk_out), 0);
    rst_n = 1'b1;
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      smp(v);
      if (v !== 1'b0) bad++;
    end
    chk("R9 idle after reset", bad, 0);

    // R1 / R3: codes 0..31, no prescale (pre_half toggled to show it is ignored)
    for (int c = 0; c < 32; c++) run_cfg(c, c[0], 1'b1, 1'b0, "R1 R3 period");
    // R2: prescale by 2 and by 4
    for (int c = 0; c < 32; c++) run_cfg(c, 1'b1, 1'b0, 1'b0, "R2 period div2");
    for (int c = 0; c < 32; c++) run_cfg(c, 1'b0, 1'b0, 1'b0, "R2 period div4");
    // R5: external reference never prescales
    run_cfg(3, 1'b0, 1'b0, 1'b1, "R5 period ext");
    run_cfg(8, 1'b1, 1'b0, 1'b1, "R5 period ext");
    // R1 extremes
    run_cfg(255, 1'b0, 1'b0, 1'b0, "R1 period code255");
    run_cfg(511, 1'b0, 1'b1, 1'b0, "R1 period code511");

    // R7: disable during a high phase (code 5: D=7, high 4, low 3)
    park(5, 1'b0, 1'b1, 1'b0);
    out_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      smp(v);
      if (v) break;
    end
    smp(v);
    out_en = 1'b0;
    run_len(1'b1, cnt);
    chk("R7 high phase kept whole", cnt + 1, 4);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      smp(v);
      if (v) bad++;
    end
    chk("R7 stays low after drop", bad, 0);

    // R7: disable during a low phase
    out_en = 1'b1;
    for (int i = 0; i < 20; i++) begin
      smp(v);
      if (v) break;
    end
    for (int i = 0; i < 20; i++) begin
      smp(v);
      if (!v) break;
    end
    out_en = 1'b0;
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      smp(v);
      if (v) bad++;
    end
    chk("R7 no new pulse after low drop", bad, 0);

    // R4 / R5: full bypass follows the master clock, code ignored
    for (int e = 0; e < 2; e++) begin
      park(123, 1'b0, 1'b0, e[0]);
      full_skip = 1'b1;
      out_en    = 1'b1;
      repeat (5) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 6; i++) begin
        @(posedge clk);
        #2;
        if (clk_out !== 1'b1) bad++;
        @(negedge clk);
        #2;
        if (clk_out !== 1'b0) bad++;
      end
      chk(e ? "R5 bypass follows clock ext" : "R4 bypass follows clock", bad, 0);
      @(negedge clk);
      out_en = 1'b0;
      repeat (5) @(negedge clk);
      bad = 0;
      for (int i = 0; i < 6; i++) begin
        @(posedge clk);
        #2;
        if (clk_out !== 1'b0) bad++;
      end
      chk("R4 bypass gated off", bad, 0);
      full_skip = 1'b0;
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule